// File: doc/BRIEF.md
# Command-Gated Serial Register Interface

This block is a three-wire synchronous serial slave that gives a host indirect access to the register file of a converter. The host never addresses a register directly. Each transaction opens with an 8-bit command byte that names one register and says whether the next access reads it or writes it. The block then shifts exactly as many data bits as that register holds and returns to waiting for the next command. The serial clock idles high. On each falling edge the block samples the input bit and moves its output to the next bit, most significant bit first.

The block also keeps the latest conversion result and drives an active-low ready line. The line falls when a new result arrives. It rises again once the result register has been read in full. The same result can be read again while the line is high. If a new result arrives while the result register is being shifted out, the word on the wire is not disturbed: the new value is held aside and takes effect when the read ends.

The controller is built around a three-state machine. `ST_CMD` collects the command byte. It moves to `ST_WRITE` or `ST_READ` on the eighth falling edge, depending on the direction bit. Both data states return to `ST_CMD` on the last bit of the addressed register.

Top module: `cmd_serial_regif`

## Requirements
- R1: After reset `rdy_n` is 1 and `dout` is 0. The block waits for a command. Mode, channel control and port control registers read 0, the filter register reads 69 (0x45), the result register and all offset slots read 0, and all gain slots read 2^(DW-1).
- R2: In the command byte, bit 6 selects a read (1) or a write (0) and bits 3:0 give the register address. Bits 7, 5 and 4 are ignored. Once the addressed access completes, the next 8 bits are taken as a new command.
- R3: `din` is sampled on each falling edge of `sclk`. Data travels most significant bit first. In a read, the first data bit is on `dout` before the first falling edge of the data phase, and each falling edge advances `dout` to the next bit.
- R4: Address map, with access lengths:
  - 1: status, 8 bits, read-only. Bit 7 is 1 while an unread result is waiting.
  - 2: mode, 8 bits.
  - 3: channel control, 8 bits. The channel number is in bits 7:4.
  - 4: filter, 8 bits.
  - 5: result, DW bits, read-only.
  - 6: offset, DW bits.
  - 7: gain, DW bits.
  - 8: port control, 8 bits.
  - 15: identity, 8 bits, read-only, value ID_VAL (0xC3 by default).
  - Every other address is undefined and has an access length of 8 bits.
- R5: A write to the status, result or identity register changes no register.
- R6: A read of an undefined address returns 0. A write to an undefined address changes no register.
- R7: Addresses 6 and 7 reach one of NSLOT (5) slots. With mode bit 0 clear (fully differential), the slot is the channel number. With mode bit 0 set (pseudo-differential), the slot is the channel number shifted right by one, so channel pairs share a slot. A computed slot above NSLOT-1 selects slot NSLOT-1.
- R8: A `conv_valid` pulse while the result register is not being read loads `conv_data` into it, and `rdy_n` falls on the next cycle. The completion of a result read drives `rdy_n` high. Further reads return the same value and leave `rdy_n` high.
- R9: A `conv_valid` pulse during a result read leaves both the shifted word and `rdy_n` unchanged until the read ends. The new value is then loaded and `rdy_n` goes low.
- R10: `dout` is 0 whenever the block is not in the data phase of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host; idles high, falling edge active |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data to the host |
| rdy_n | output | 1 | Active-low flag for an unread conversion result |
| conv_valid | input | 1 | One-cycle strobe announcing a new conversion result |
| conv_data | input | DW | Conversion result accompanying `conv_valid` |

## Verification
The bench goes after three corner cases.

The first is a conversion update landing in the middle of a result read. A design that loads it at once would corrupt the word on the wire or drop `rdy_n` early. A design that discards it would leave `rdy_n` high and serve the stale value next time.

The second is a group of access boundaries: a re-read of the result after the ready flag has cleared, writes aimed at read-only and undefined addresses, and command bytes carrying junk in the ignored bits. Miscounted lengths or a leaky write decode show up here as misframed later transactions or altered read-back values.

The third is slot selection under both channel modes, including a channel beyond the last slot. A wrong shift or a missing clamp makes a read return another channel's coefficient.

// File: rtl/srif_pkg.sv
package srif_pkg;

    typedef enum logic [1:0] {
        ST_CMD   = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } srif_state_e;

    localparam logic [3:0] A_STATUS = 4'd1;
    localparam logic [3:0] A_MODE   = 4'd2;
    localparam logic [3:0] A_CHAN   = 4'd3;
    localparam logic [3:0] A_FILT   = 4'd4;
    localparam logic [3:0] A_DATA   = 4'd5;
    localparam logic [3:0] A_OFFS   = 4'd6;
    localparam logic [3:0] A_GAIN   = 4'd7;
    localparam logic [3:0] A_PORT   = 4'd8;
    localparam logic [3:0] A_ID     = 4'd15;

    // registers whose access length is the full result width
    function automatic logic is_wide(input logic [3:0] a);
        return (a == A_DATA) || (a == A_OFFS) || (a == A_GAIN);
    endfunction

endpackage

// File: rtl/srif_sync.sv
module srif_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic din,
    output logic fall,
    output logic din_s
);
    logic sclk_m, sclk_s, sclk_d, din_m;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_m <= 1'b1;
            sclk_s <= 1'b1;
            sclk_d <= 1'b1;
            din_m  <= 1'b0;
            din_s  <= 1'b0;
        end else begin
            sclk_m <= sclk;
            sclk_s <= sclk_m;
            sclk_d <= sclk_s;
            din_m  <= din;
            din_s  <= din_m;
        end
    end

    assign fall = sclk_d & ~sclk_s;
endmodule

// File: rtl/srif_ready.sv
module srif_ready #(
    parameter int unsigned DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          conv_valid,
    input  logic [DW-1:0] conv_data,
    input  logic          rd_busy,
    input  logic          rd_done,
    output logic [DW-1:0] data_q,
    output logic          fresh_q
);
    logic [DW-1:0] pend_q;
    logic          pend_v_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q   <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
            fresh_q  <= 1'b0;
        end else if (rd_done) begin
            pend_v_q <= 1'b0;
            if (conv_valid) begin
                data_q  <= conv_data;
                fresh_q <= 1'b1;
            end else if (pend_v_q) begin
                data_q  <= pend_q;
                fresh_q <= 1'b1;
            end else begin
                fresh_q <= 1'b0;
            end
        end else if (conv_valid) begin
            if (rd_busy) begin
                pend_q   <= conv_data;
                pend_v_q <= 1'b1;
            end else begin
                data_q  <= conv_data;
                fresh_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/srif_regfile.sv
module srif_regfile
    import srif_pkg::*;
#(
    parameter int unsigned DW       = 24,
    parameter int unsigned NSLOT    = 5,
    parameter logic [7:0]  FILT_RST = 8'd69,
    parameter logic [7:0]  ID_VAL   = 8'hC3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [3:0]    wr_addr,
    input  logic [DW-1:0] wr_val,
    input  logic [3:0]    rd_addr,
    input  logic          fresh,
    input  logic [DW-1:0] data_val,
    output logic [DW-1:0] rd_val
);
    localparam int unsigned SW        = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam logic [3:0]  LAST_SLOT = 4'(NSLOT - 1);
    localparam logic [DW-1:0] GAIN_RST = {1'b1, {(DW-1){1'b0}}};

    logic [7:0]    mode_q, chan_q, filt_q, port_q;
    logic [DW-1:0] offs_q [NSLOT];
    logic [DW-1:0] gain_q [NSLOT];
    logic [3:0]    idx;
    logic [SW-1:0] slot;

    assign idx  = mode_q[0] ? {1'b0, chan_q[7:5]} : chan_q[7:4];
    assign slot = (idx > LAST_SLOT) ? LAST_SLOT[SW-1:0] : idx[SW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            chan_q <= '0;
            filt_q <= FILT_RST;
            port_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_MODE:  mode_q <= wr_val[7:0];
                A_CHAN:  chan_q <= wr_val[7:0];
                A_FILT:  filt_q <= wr_val[7:0];
                A_PORT:  port_q <= wr_val[7:0];
                default: ;
            endcase
        end
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                offs_q[s] <= '0;
                gain_q[s] <= GAIN_RST;
            end else if (wr_en && slot == SW'(s)) begin
                if (wr_addr == A_OFFS) offs_q[s] <= wr_val;
                if (wr_addr == A_GAIN) gain_q[s] <= wr_val;
            end
        end
    end

    always_comb begin
        rd_val = '0;
        case (rd_addr)
            A_STATUS: rd_val[7:0] = {fresh, 7'b0};
            A_MODE:   rd_val[7:0] = mode_q;
            A_CHAN:   rd_val[7:0] = chan_q;
            A_FILT:   rd_val[7:0] = filt_q;
            A_DATA:   rd_val      = data_val;
            A_OFFS:   rd_val      = offs_q[slot];
            A_GAIN:   rd_val      = gain_q[slot];
            A_PORT:   rd_val[7:0] = port_q;
            A_ID:     rd_val[7:0] = ID_VAL;
            default:  rd_val      = '0;
        endcase
    end
endmodule

// File: rtl/cmd_serial_regif.sv
module cmd_serial_regif
    import srif_pkg::*;
#(
    parameter int unsigned DW       = 24,
    parameter int unsigned NSLOT    = 5,
    parameter logic [7:0]  FILT_RST = 8'd69,
    parameter logic [7:0]  ID_VAL   = 8'hC3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk,
    input  logic          din,
    output logic          dout,
    output logic          rdy_n,
    input  logic          conv_valid,
    input  logic [DW-1:0] conv_data
);
    localparam int unsigned CW = $clog2(DW);

    srif_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q, last_q;
    logic [DW-1:0] shreg_q, shnext, rd_val, data_q;
    logic [3:0]    addr_q;
    logic          fall, din_s, fresh;
    logic          cmd_last, data_last, wr_en, rd_busy, rd_done;

    srif_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sclk),
        .din   (din),
        .fall  (fall),
        .din_s (din_s)
    );

    assign shnext    = {shreg_q[DW-2:0], din_s};
    assign cmd_last  = fall && (state_q == ST_CMD) && (cnt_q == CW'(7));
    assign data_last = fall && (state_q != ST_CMD) && (cnt_q == last_q);
    assign wr_en     = data_last && (state_q == ST_WRITE);
    assign rd_busy   = (state_q == ST_READ) && (addr_q == A_DATA);
    assign rd_done   = data_last && rd_busy;

    srif_regfile #(
        .DW       (DW),
        .NSLOT    (NSLOT),
        .FILT_RST (FILT_RST),
        .ID_VAL   (ID_VAL)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (addr_q),
        .wr_val   (shnext),
        .rd_addr  (shnext[3:0]),
        .fresh    (fresh),
        .data_val (data_q),
        .rd_val   (rd_val)
    );

    srif_ready #(.DW(DW)) u_ready (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_valid (conv_valid),
        .conv_data  (conv_data),
        .rd_busy    (rd_busy),
        .rd_done    (rd_done),
        .data_q     (data_q),
        .fresh_q    (fresh)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CMD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CMD:   if (cmd_last)  state_d = shnext[6] ? ST_READ : ST_WRITE;
            ST_WRITE: if (data_last) state_d = ST_CMD;
            ST_READ:  if (data_last) state_d = ST_CMD;
            default:  state_d = ST_CMD;
        endcase
    end

    // counter, shifter and address capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            last_q  <= CW'(7);
            shreg_q <= '0;
            addr_q  <= '0;
        end else if (fall) begin
            unique case (state_q)
                ST_CMD: begin
                    if (cnt_q == CW'(7)) begin
                        cnt_q  <= '0;
                        addr_q <= shnext[3:0];
                        last_q <= is_wide(shnext[3:0]) ? CW'(DW - 1) : CW'(7);
                        if (!shnext[6])
                            shreg_q <= '0;
                        else if (is_wide(shnext[3:0]))
                            shreg_q <= rd_val;
                        else
                            shreg_q <= {rd_val[7:0], {(DW-8){1'b0}}};
                    end else begin
                        cnt_q   <= cnt_q + 1'b1;
                        shreg_q <= shnext;
                    end
                end
                ST_WRITE: begin
                    if (cnt_q == last_q) begin
                        cnt_q   <= '0;
                        shreg_q <= '0;
                    end else begin
                        cnt_q   <= cnt_q + 1'b1;
                        shreg_q <= shnext;
                    end
                end
                ST_READ: begin
                    if (cnt_q == last_q) begin
                        cnt_q   <= '0;
                        shreg_q <= '0;
                    end else begin
                        cnt_q   <= cnt_q + 1'b1;
                        shreg_q <= {shreg_q[DW-2:0], 1'b0};
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    assign dout  = (state_q == ST_READ) & shreg_q[DW-1];
    assign rdy_n = ~fresh;
endmodule

// File: rtl/srif_chk.sv
module srif_chk
    import srif_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input srif_state_e state_q,
    input logic        fall,
    input logic        dout,
    input logic        rdy_n,
    input logic        conv_valid,
    input logic        rd_busy,
    input logic        rd_done,
    input logic        data_last
);
    a_r10_dout_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_READ) |-> !dout)
        else $error("dout active outside read phase");

    a_r3_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && !fall) |=> $stable(dout))
        else $error("dout moved without a falling sclk edge");

    a_r2_back_to_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        data_last |=> (state_q == ST_CMD))
        else $error("no return to command state after last bit");

    a_r8_rdy_set: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid && !rd_busy) |=> !rdy_n)
        else $error("ready not raised on new result");

    a_r9_rdy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_busy && conv_valid && !rd_done) |=> $stable(rdy_n))
        else $error("ready changed by update during result read");
endmodule

bind cmd_serial_regif srif_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .fall       (fall),
    .dout       (dout),
    .rdy_n      (rdy_n),
    .conv_valid (conv_valid),
    .rd_busy    (rd_busy),
    .rd_done    (rd_done),
    .data_last  (data_last)
);

// File: tb/cmd_serial_regif_test.sv
module cmd_serial_regif_test;
    localparam int DW   = 24;
    localparam int HALF = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sclk = 1'b1;
    logic          din = 1'b0;
    logic          conv_valid = 1'b0;
    logic [DW-1:0] conv_data = '0;
    logic          dout, rdy_n;

    int tests = 0;
    int fails = 0;

    typedef struct {
        string       req;
        logic [31:0] val;
    } item_t;

    item_t       exp_q[$];
    logic [31:0] act_q[$];

    always #4 clk = ~clk;

    cmd_serial_regif #(.DW(DW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (sclk),
        .din        (din),
        .dout       (dout),
        .rdy_n      (rdy_n),
        .conv_valid (conv_valid),
        .conv_data  (conv_data)
    );

    function automatic int acc_len(input logic [3:0] a);
        return (a == 4'd5 || a == 4'd6 || a == 4'd7) ? DW : 8;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0) begin
                logic [31:0] a;
                a = act_q.pop_front();
                if (exp_q.size() == 0) begin
                    chk("scoreboard-extra", a, 32'hDEAD_BEEF);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    chk(e.req, a, e.val);
                end
            end
        end
    end

    task automatic xfer_bit(input logic b, output logic o);
        din = b;
        repeat (HALF) @(negedge clk);
        o = dout;
        sclk = 1'b0;
        repeat (HALF) @(negedge clk);
        sclk = 1'b1;
    endtask

    task automatic do_rd(input logic [7:0] cmd);
        logic        o;
        logic [31:0] v;
        v = '0;
        for (int i = 7; i >= 0; i--) xfer_bit(cmd[i], o);
        for (int i = 0; i < acc_len(cmd[3:0]); i++) begin
            xfer_bit(1'b0, o);
            v = {v[30:0], o};
        end
        act_q.push_back(v);
    endtask

    task automatic rd_exp(input logic [7:0] cmd, input string req, input logic [31:0] val);
        item_t e;
        e.req = req;
        e.val = val;
        exp_q.push_back(e);
        do_rd(cmd);
    endtask

    task automatic do_wr(input logic [7:0] cmd, input logic [31:0] val, output logic seen);
        logic o;
        seen = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            xfer_bit(cmd[i], o);
            seen |= o;
        end
        for (int i = acc_len(cmd[3:0]) - 1; i >= 0; i--) begin
            xfer_bit(val[i], o);
            seen |= o;
        end
    endtask

    task automatic wr(input logic [7:0] cmd, input logic [31:0] val);
        logic s;
        do_wr(cmd, val, s);
    endtask

    task automatic pulse_conv(input logic [DW-1:0] v);
        @(negedge clk);
        conv_data  = v;
        conv_valid = 1'b1;
        @(negedge clk);
        conv_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic seen;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        chk("R1 rdy_n at reset", 32'(rdy_n), 32'd1);
        chk("R1 dout at reset", 32'(dout), 32'd0);
        rd_exp(8'h44, "R1 filter reset", 32'h45);
        rd_exp(8'h42, "R1 mode reset", 32'h00);
        rd_exp(8'h46, "R1 offset reset", 32'h0);
        rd_exp(8'h47, "R1 gain reset", 32'h800000);
        rd_exp(8'h45, "R1 result reset", 32'h0);

        // R4 8-bit registers; R10 dout quiet during writes
        do_wr(8'h08, 32'h3C, seen);
        chk("R10 dout low during write", 32'(seen), 32'd0);
        rd_exp(8'h48, "R4 port control", 32'h3C);
        wr(8'h04, 32'h0D);
        rd_exp(8'h44, "R4 filter", 32'h0D);
        // R2 ignored command bits
        wr(8'hB2, 32'h80);
        rd_exp(8'hF2, "R2 mode via junk command bits", 32'h80);

        // R7 fully differential slots, R3 wide MSB-first transfers
        wr(8'h03, 32'h00);
        wr(8'h06, 32'h0A0B0C);
        wr(8'h03, 32'h10);
        wr(8'h06, 32'h111111);
        wr(8'h03, 32'h00);
        rd_exp(8'h46, "R3 R7 offset slot0", 32'h0A0B0C);
        wr(8'h03, 32'h10);
        rd_exp(8'h46, "R7 offset slot1", 32'h111111);
        // R7 pseudo-differential pairing
        wr(8'h02, 32'h01);
        wr(8'h03, 32'h20);
        rd_exp(8'h46, "R7 pseudo ch2 shares slot1", 32'h111111);
        wr(8'h03, 32'h30);
        wr(8'h07, 32'h5A5A5A);
        wr(8'h03, 32'h20);
        rd_exp(8'h47, "R7 pseudo ch3/ch2 gain shared", 32'h5A5A5A);
        wr(8'h02, 32'h00);
        wr(8'h03, 32'h30);
        rd_exp(8'h47, "R7 fully ch3 own gain", 32'h800000);
        // R7 clamp to last slot
        wr(8'h03, 32'h90);
        wr(8'h06, 32'h777777);
        wr(8'h03, 32'h40);
        rd_exp(8'h46, "R7 clamp to slot4", 32'h777777);

        // R5 read-only registers
        wr(8'h0F, 32'h00);
        rd_exp(8'h4F, "R5 identity unchanged", 32'hC3);
        wr(8'h01, 32'hFF);
        rd_exp(8'h41, "R5 status unchanged", 32'h00);

        // R6 undefined addresses
        wr(8'h09, 32'hFF);
        rd_exp(8'h49, "R6 undefined read", 32'h00);
        rd_exp(8'h40, "R6 address 0 read", 32'h00);
        rd_exp(8'h42, "R6 mode untouched", 32'h00);

        // R8 ready handshake
        pulse_conv(24'h123456);
        @(negedge clk);
        chk("R8 rdy_n low after update", 32'(rdy_n), 32'd0);
        rd_exp(8'h41, "R4 status ready bit", 32'h80);
        chk("R8 status read keeps ready", 32'(rdy_n), 32'd0);
        rd_exp(8'h45, "R8 result", 32'h123456);
        repeat (4) @(negedge clk);
        chk("R8 rdy_n high after read", 32'(rdy_n), 32'd1);
        rd_exp(8'h45, "R8 re-read same result", 32'h123456);
        chk("R8 rdy_n stays high", 32'(rdy_n), 32'd1);
        wr(8'h05, 32'hFFFFFF);
        rd_exp(8'h45, "R5 result write ignored", 32'h123456);

        // R9 update during result read
        pulse_conv(24'h111111);
        rd_exp(8'h45, "R9 setup read", 32'h111111);
        fork
            rd_exp(8'h45, "R9 word not corrupted", 32'h111111);
            begin
                repeat (250) @(negedge clk);
                pulse_conv(24'h222222);
                repeat (20) @(negedge clk);
                chk("R9 rdy_n held during read", 32'(rdy_n), 32'd1);
            end
        join
        repeat (4) @(negedge clk);
        chk("R9 rdy_n low after read", 32'(rdy_n), 32'd0);
        rd_exp(8'h45, "R9 deferred result", 32'h222222);

        wait (act_q.size() == 0);
        repeat (4) @(negedge clk);
        chk("scoreboard drained", 32'(exp_q.size()), 32'd0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule